// File: doc/BRIEF.md
# Host-to-Controller Byte Mailbox Channel

This block is one byte-wide mailbox between a host bus and an embedded controller, of the kind that carries keyboard-controller or power-management traffic. The host writes a byte through either a data port or a command port, reads back a status byte, and reads the byte the controller has posted. The controller picks up the host's byte, posts a reply byte, keeps a firmware-owned busy flag and four general flags that the host can see, and programs interrupt enables and a flag-clear mode through a control write. Host address decoding sits outside: the host side is a set of single-cycle strobes.

Two small state machines hold the buffer flags. The input machine has the states IB_EMPTY and IB_FULL. A host write moves it to IB_FULL (transition FILL) and keeps it there if it is already full (transition OVERWRITE, which also sets a sticky overrun flag). It returns to IB_EMPTY on a host reset (transition HRESET) or when the controller drains it (transition DRAIN). In access mode (clear-mode bit 0) a controller read drains it. In strobe mode (clear-mode bit 1) only a write of 1 to control bit 7 drains it. The output machine has the states OB_EMPTY and OB_FULL. A controller write moves it to OB_FULL (transition POST). It returns to OB_EMPTY when the host reads the data port (transition TAKE) or, in strobe mode only, when the controller writes 1 to control bit 6 (transition FLUSH). Level interrupts to the controller come from the flags and the enables.

Top module: `host_mbox_channel`

## Requirements
- R1: A host write (`h_wr`) stores `h_wdata` as the input byte (seen on `c_rdata`) and sets input-full, status bit 1, from the next cycle. Status bit 3 becomes 1 if `h_cmd_sel` was 1 for that write and 0 if it was 0.
- R2: A controller write (`c_wr`) stores `c_wdata` as the output byte (seen on `h_rdata`) and sets output-full, status bit 0. A host data read (`h_rd`) clears output-full in both clear modes.
- R3: With clear-mode (control bit 5) at 0, a controller read (`c_rd`) clears input-full. Writes of 1 to control bits 7 and 6 then leave both full flags unchanged.
- R4: With clear-mode at 1, a controller read leaves input-full set. A control write with bit 7 at 1 clears input-full, and a control write with bit 6 at 1 clears output-full. The clear-mode in force before the control write decides this.
- R5: A host reset (`h_rst`) clears input-full only. A controller reset (`rst_n` low) clears every flag, both enables, the clear-mode, busy, the general flags and the overrun flag, so the status reads 0x00.
- R6: `irq_ibf` is high exactly when input-full is set and control bit 0 is set. `irq_obe` is high exactly when output-full is clear and control bit 1 is set.
- R7: A status write (`c_stat_wr`) loads `c_busy` into status bit 2 and `c_gflags` into status bits 7:4, leaving bits 3:0 other than bit 2 unchanged.
- R8: A host write while input-full is set overwrites the input byte and sets `c_overrun`. `c_overrun` stays set until a control write with bit 4 at 1. A new overrun in the same cycle wins over that clear.
- R9: In one cycle, a host write wins over a controller drain of input-full, and a controller write wins over a host read or strobe clear of output-full. A host reset wins over a host write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Controller reset, active low, asynchronous |
| h_rst | input | 1 | Host reset, synchronous, active high |
| h_wr | input | 1 | Host write strobe |
| h_cmd_sel | input | 1 | 1: the write targets the command port, 0: the data port |
| h_wdata | input | 8 | Host write byte |
| h_rd | input | 1 | Host data-port read strobe |
| h_rdata | output | 8 | Output byte, read by the host |
| h_status | output | 8 | Status: bit0 output-full, bit1 input-full, bit2 busy, bit3 last-was-command, bits 7:4 general flags |
| c_rd | input | 1 | Controller read strobe of the input byte |
| c_rdata | output | 8 | Input byte, read by the controller |
| c_wr | input | 1 | Controller write strobe of the output byte |
| c_wdata | input | 8 | Output byte from the controller |
| c_ctl_wr | input | 1 | Control write strobe |
| c_ctl_wdata | input | 8 | Control: bit0 input-full irq enable, bit1 output-empty irq enable, bit4 clear overrun, bit5 clear-mode, bit6 clear output-full, bit7 clear input-full |
| c_stat_wr | input | 1 | Status write strobe |
| c_busy | input | 1 | Busy value loaded by a status write |
| c_gflags | input | 4 | General flags loaded by a status write |
| c_overrun | output | 1 | Sticky input overrun flag |
| irq_ibf | output | 1 | Level interrupt: input buffer full |
| irq_obe | output | 1 | Level interrupt: output buffer empty |

## Verification
The assertions expect every strobe to be a clean level that is sampled at a rising edge and is never X after reset. They expect `h_rst` to be driven only while `rst_n` is high, because the controller reset already clears what the host reset would. The stimulus drives all inputs on falling edges and keeps them for one full cycle. A random phase fires any mix of strobes at once, including the colliding set/clear pairs, so the priorities of R9 are exercised against the bench's own model every cycle.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int DW = 8;
    localparam int GFW = 4;

    // host status bit positions
    localparam int ST_OBF  = 0;
    localparam int ST_IBF  = 1;
    localparam int ST_BUSY = 2;
    localparam int ST_CMD  = 3;
    localparam int ST_GF_LO = 4;

    // controller control bit positions
    localparam int CT_IBF_IE  = 0;
    localparam int CT_OBE_IE  = 1;
    localparam int CT_OVR_CLR = 4;
    localparam int CT_MODE    = 5;
    localparam int CT_OBF_CLR = 6;
    localparam int CT_IBF_CLR = 7;

    typedef enum logic {IB_EMPTY, IB_FULL} ib_state_e;
    typedef enum logic {OB_EMPTY, OB_FULL} ob_state_e;
endpackage

// File: rtl/mbox_inbuf.sv
module mbox_inbuf
    import mbox_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         h_rst,
    input  logic         h_wr,
    input  logic         h_cmd_sel,
    input  logic [W-1:0] h_wdata,
    input  logic         c_rd,
    input  logic         strobe_mode,
    input  logic         drain_stb,
    input  logic         ovr_clr,
    output logic         ibf,
    output logic         last_cmd,
    output logic [W-1:0] in_byte,
    output logic         overrun
);
    ib_state_e st_q, st_d;
    logic      drain;
    logic      cmd_q;
    logic      ovr_q;
    logic [W-1:0] byte_q;

    assign drain = strobe_mode ? drain_stb : c_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= IB_EMPTY;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            IB_EMPTY: begin
                if (h_rst)     st_d = IB_EMPTY;   // HRESET
                else if (h_wr) st_d = IB_FULL;    // FILL
            end
            IB_FULL: begin
                if (h_rst)      st_d = IB_EMPTY;  // HRESET
                else if (h_wr)  st_d = IB_FULL;   // OVERWRITE
                else if (drain) st_d = IB_EMPTY;  // DRAIN
            end
            default: st_d = IB_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q <= '0;
            cmd_q  <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (h_wr) begin
                byte_q <= h_wdata;
                cmd_q  <= h_cmd_sel;
            end
            if (h_wr && st_q == IB_FULL) ovr_q <= 1'b1;
            else if (ovr_clr)            ovr_q <= 1'b0;
        end
    end

    always_comb begin
        ibf      = (st_q == IB_FULL);
        last_cmd = cmd_q;
        in_byte  = byte_q;
        overrun  = ovr_q;
    end

    a_r1_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && !h_rst) |=> ibf);
    a_r1_port_flag: assert property (@(posedge clk) disable iff (!rst_n)
        h_wr |=> (last_cmd == $past(h_cmd_sel)));
    a_r3_access_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_mode && c_rd && !h_wr) |=> !ibf);
    a_r4_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_mode && ibf && !drain_stb && !h_rst) |=> ibf);
    a_r5_host_reset: assert property (@(posedge clk) disable iff (!rst_n)
        h_rst |=> !ibf);
    a_r8_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && ibf) |=> overrun);
    a_r8_overrun_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun);
endmodule

// File: rtl/mbox_outbuf.sv
module mbox_outbuf
    import mbox_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         c_wr,
    input  logic [W-1:0] c_wdata,
    input  logic         h_rd,
    input  logic         flush_stb,
    output logic         obf,
    output logic [W-1:0] out_byte
);
    ob_state_e st_q, st_d;
    logic [W-1:0] byte_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= OB_EMPTY;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            OB_EMPTY: begin
                if (c_wr) st_d = OB_FULL;              // POST
            end
            OB_FULL: begin
                if (c_wr)           st_d = OB_FULL;    // POST again
                else if (h_rd)      st_d = OB_EMPTY;   // TAKE
                else if (flush_stb) st_d = OB_EMPTY;   // FLUSH
            end
            default: st_d = OB_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    byte_q <= '0;
        else if (c_wr) byte_q <= c_wdata;
    end

    always_comb begin
        obf      = (st_q == OB_FULL);
        out_byte = byte_q;
    end

    a_r2_post: assert property (@(posedge clk) disable iff (!rst_n)
        c_wr |=> (obf && out_byte == $past(c_wdata)));
    a_r2_take: assert property (@(posedge clk) disable iff (!rst_n)
        (h_rd && !c_wr) |=> !obf);
    a_r4_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_stb && !c_wr) |=> !obf);
    a_r9_post_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr && (h_rd || flush_stb)) |=> obf);
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
    import mbox_pkg::*;
#(
    parameter int W = DW,
    parameter int G = GFW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         c_ctl_wr,
    input  logic [W-1:0] c_ctl_wdata,
    input  logic         c_stat_wr,
    input  logic         c_busy,
    input  logic [G-1:0] c_gflags,
    input  logic         ibf,
    input  logic         obf,
    output logic         strobe_mode,
    output logic         ibf_clr_stb,
    output logic         obf_clr_stb,
    output logic         ovr_clr_stb,
    output logic         busy,
    output logic [G-1:0] gflags,
    output logic         irq_ibf,
    output logic         irq_obe
);
    logic         ie_ibf_q, ie_obe_q, mode_q, busy_q;
    logic [G-1:0] gf_q;
    logic         ctl_unused;

    assign ctl_unused = ^{c_ctl_wdata[3:2], c_ctl_wdata[W-1:CT_IBF_CLR]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_ibf_q <= 1'b0;
            ie_obe_q <= 1'b0;
            mode_q   <= 1'b0;
        end else if (c_ctl_wr) begin
            ie_ibf_q <= c_ctl_wdata[CT_IBF_IE];
            ie_obe_q <= c_ctl_wdata[CT_OBE_IE];
            mode_q   <= c_ctl_wdata[CT_MODE];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            gf_q   <= '0;
        end else if (c_stat_wr) begin
            busy_q <= c_busy;
            gf_q   <= c_gflags;
        end
    end

    always_comb begin
        strobe_mode = mode_q;
        ibf_clr_stb = c_ctl_wr && mode_q && c_ctl_wdata[CT_IBF_CLR];
        obf_clr_stb = c_ctl_wr && mode_q && c_ctl_wdata[CT_OBF_CLR];
        ovr_clr_stb = c_ctl_wr && c_ctl_wdata[CT_OVR_CLR];
        busy        = busy_q;
        gflags      = gf_q;
        irq_ibf     = ibf && ie_ibf_q;
        irq_obe     = !obf && ie_obe_q;
    end

    a_r6_ibf_irq_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ibf |-> ibf);
    a_r6_obe_irq_needs_empty: assert property (@(posedge clk) disable iff (!rst_n)
        irq_obe |-> !obf);
    a_r7_busy_load: assert property (@(posedge clk) disable iff (!rst_n)
        c_stat_wr |=> (busy == $past(c_busy) && gflags == $past(c_gflags)));
    a_r7_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !c_stat_wr |=> $stable(busy));
    a_r3_no_strobe_in_access: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_mode |-> !(ibf_clr_stb || obf_clr_stb));
endmodule

// File: rtl/host_mbox_channel.sv
module host_mbox_channel
    import mbox_pkg::*;
#(
    parameter int W = DW,
    parameter int G = GFW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         h_rst,
    input  logic         h_wr,
    input  logic         h_cmd_sel,
    input  logic [W-1:0] h_wdata,
    input  logic         h_rd,
    output logic [W-1:0] h_rdata,
    output logic [W-1:0] h_status,
    input  logic         c_rd,
    output logic [W-1:0] c_rdata,
    input  logic         c_wr,
    input  logic [W-1:0] c_wdata,
    input  logic         c_ctl_wr,
    input  logic [W-1:0] c_ctl_wdata,
    input  logic         c_stat_wr,
    input  logic         c_busy,
    input  logic [G-1:0] c_gflags,
    output logic         c_overrun,
    output logic         irq_ibf,
    output logic         irq_obe
);
    logic         ibf, obf, last_cmd, busy;
    logic         strobe_mode, ibf_clr_stb, obf_clr_stb, ovr_clr_stb;
    logic [G-1:0] gflags;

    mbox_inbuf #(.W(W)) u_in (
        .clk(clk), .rst_n(rst_n), .h_rst(h_rst), .h_wr(h_wr),
        .h_cmd_sel(h_cmd_sel), .h_wdata(h_wdata), .c_rd(c_rd),
        .strobe_mode(strobe_mode), .drain_stb(ibf_clr_stb),
        .ovr_clr(ovr_clr_stb), .ibf(ibf), .last_cmd(last_cmd),
        .in_byte(c_rdata), .overrun(c_overrun)
    );

    mbox_outbuf #(.W(W)) u_out (
        .clk(clk), .rst_n(rst_n), .c_wr(c_wr), .c_wdata(c_wdata),
        .h_rd(h_rd), .flush_stb(obf_clr_stb), .obf(obf), .out_byte(h_rdata)
    );

    mbox_ctrl #(.W(W), .G(G)) u_ctl (
        .clk(clk), .rst_n(rst_n), .c_ctl_wr(c_ctl_wr),
        .c_ctl_wdata(c_ctl_wdata), .c_stat_wr(c_stat_wr), .c_busy(c_busy),
        .c_gflags(c_gflags), .ibf(ibf), .obf(obf),
        .strobe_mode(strobe_mode), .ibf_clr_stb(ibf_clr_stb),
        .obf_clr_stb(obf_clr_stb), .ovr_clr_stb(ovr_clr_stb),
        .busy(busy), .gflags(gflags), .irq_ibf(irq_ibf), .irq_obe(irq_obe)
    );

    always_comb begin
        h_status                      = '0;
        h_status[ST_OBF]              = obf;
        h_status[ST_IBF]              = ibf;
        h_status[ST_BUSY]             = busy;
        h_status[ST_CMD]              = last_cmd;
        h_status[ST_GF_LO+G-1:ST_GF_LO] = gflags;
    end

    a_r9_write_beats_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && !h_rst && (c_rd || ibf_clr_stb)) |=> h_status[ST_IBF]);
    a_r5_host_reset_keeps_obf: assert property (@(posedge clk) disable iff (!rst_n)
        (h_rst && obf && !h_rd && !obf_clr_stb) |=> h_status[ST_OBF]);
endmodule

// File: tb/sim_host_mbox_channel.sv
`timescale 1ns/1ps
module sim_host_mbox_channel;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic h_rst = 0, h_wr = 0, h_cmd_sel = 0, h_rd = 0;
    logic c_rd = 0, c_wr = 0, c_ctl_wr = 0, c_stat_wr = 0, c_busy = 0;
    logic [7:0] h_wdata = 0, c_wdata = 0, c_ctl_wdata = 0;
    logic [3:0] c_gflags = 0;
    logic [7:0] h_rdata, h_status, c_rdata;
    logic c_overrun, irq_ibf, irq_obe;

    always #4 clk = ~clk;

    host_mbox_channel u0 (
        .clk(clk), .rst_n(rst_n), .h_rst(h_rst), .h_wr(h_wr),
        .h_cmd_sel(h_cmd_sel), .h_wdata(h_wdata), .h_rd(h_rd),
        .h_rdata(h_rdata), .h_status(h_status), .c_rd(c_rd),
        .c_rdata(c_rdata), .c_wr(c_wr), .c_wdata(c_wdata),
        .c_ctl_wr(c_ctl_wr), .c_ctl_wdata(c_ctl_wdata),
        .c_stat_wr(c_stat_wr), .c_busy(c_busy), .c_gflags(c_gflags),
        .c_overrun(c_overrun), .irq_ibf(irq_ibf), .irq_obe(irq_obe)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // behavioural reference model
    bit m_ibf, m_obf, m_cmd, m_busy, m_ovr, m_ie, m_oe, m_mode;
    bit [3:0] m_gf;
    bit [7:0] m_in, m_out;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ibf = 0; m_obf = 0; m_cmd = 0; m_busy = 0; m_ovr = 0;
            m_ie = 0; m_oe = 0; m_mode = 0; m_gf = 0; m_in = 0; m_out = 0;
        end else begin
            if (h_wr && m_ibf) m_ovr = 1;
            else if (c_ctl_wr && c_ctl_wdata[4]) m_ovr = 0;
            if (h_rst) m_ibf = 0;
            else if (h_wr) m_ibf = 1;
            else if (m_mode ? (c_ctl_wr && c_ctl_wdata[7]) : c_rd) m_ibf = 0;
            if (h_wr) begin m_in = h_wdata; m_cmd = h_cmd_sel; end
            if (c_wr) begin m_obf = 1; m_out = c_wdata; end
            else if (h_rd || (m_mode && c_ctl_wr && c_ctl_wdata[6])) m_obf = 0;
            if (c_ctl_wr) begin
                m_ie = c_ctl_wdata[0]; m_oe = c_ctl_wdata[1]; m_mode = c_ctl_wdata[5];
            end
            if (c_stat_wr) begin m_busy = c_busy; m_gf = c_gflags; end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare against the model on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R1/R2/R7 status", h_status, {m_gf, m_cmd, m_busy, m_ibf, m_obf});
            chk("R1 input byte", c_rdata, m_in);
            chk("R2 output byte", h_rdata, m_out);
            chk("R8 overrun", {7'd0, c_overrun}, {7'd0, m_ovr});
            chk("R6 irqs", {6'd0, irq_ibf, irq_obe},
                {6'd0, m_ibf && m_ie, !m_obf && m_oe});
        end
    end

    task automatic step;
        @(negedge clk);
        h_rst = 0; h_wr = 0; h_rd = 0; c_rd = 0; c_wr = 0;
        c_ctl_wr = 0; c_stat_wr = 0;
        #1;
    endtask

    task automatic finish_run;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R5 reset state
        chk("R5 reset status", h_status, 8'h00);
        chk("R5 reset irqs", {6'd0, irq_ibf, irq_obe}, 8'h00);
        rst_n = 1;
        step();

        // R1 data-port write
        h_wr = 1; h_cmd_sel = 0; h_wdata = 8'h5A; step();
        chk("R1 ibf+data port", h_status, 8'h02);
        chk("R1 byte", c_rdata, 8'h5A);
        // R3 access-mode read drains
        c_rd = 1; step();
        chk("R3 read drains", h_status, 8'h00);
        // R1 command-port write
        h_wr = 1; h_cmd_sel = 1; h_wdata = 8'hA5; step();
        chk("R1 cmd port", h_status, 8'h0A);
        // R2 post and take
        c_wr = 1; c_wdata = 8'h3C; step();
        chk("R2 obf set", {7'd0, h_status[0]}, 8'h01);
        chk("R2 out byte", h_rdata, 8'h3C);
        // R3 strobes ignored in access mode
        c_ctl_wr = 1; c_ctl_wdata = 8'hC0; step();
        chk("R3 strobes ignored", h_status[1:0], 2'b11);
        h_rd = 1; step();
        chk("R2 take clears", {7'd0, h_status[0]}, 8'h00);
        // R6 enables
        c_ctl_wr = 1; c_ctl_wdata = 8'h03; step();
        chk("R6 irq_ibf", {7'd0, irq_ibf}, 8'h01);
        chk("R6 irq_obe", {7'd0, irq_obe}, 8'h01);
        // R8 overrun on second write
        h_wr = 1; h_cmd_sel = 0; h_wdata = 8'h77; step();
        chk("R8 overrun set", {7'd0, c_overrun}, 8'h01);
        chk("R8 overwrite", c_rdata, 8'h77);
        c_ctl_wr = 1; c_ctl_wdata = 8'h13; step();
        chk("R8 overrun cleared", {7'd0, c_overrun}, 8'h00);
        // R4 strobe mode
        c_ctl_wr = 1; c_ctl_wdata = 8'h23; step();
        c_rd = 1; step();
        chk("R4 read keeps ibf", {7'd0, h_status[1]}, 8'h01);
        c_ctl_wr = 1; c_ctl_wdata = 8'hA3; step();
        chk("R4 bit7 drains", {7'd0, h_status[1]}, 8'h00);
        c_wr = 1; c_wdata = 8'h11; step();
        c_ctl_wr = 1; c_ctl_wdata = 8'h63; step();
        chk("R4 bit6 flushes", {7'd0, h_status[0]}, 8'h00);
        // R7 status write
        c_stat_wr = 1; c_busy = 1; c_gflags = 4'hA; step();
        chk("R7 busy+flags", h_status & 8'hF4, 8'hA4);
        c_stat_wr = 1; c_busy = 0; c_gflags = 4'h5; step();
        chk("R7 busy clear", h_status & 8'hF4, 8'h50);
        // R9 collisions (strobe mode active)
        h_wr = 1; h_wdata = 8'h21; step();
        h_wr = 1; h_wdata = 8'h22; c_ctl_wr = 1; c_ctl_wdata = 8'hB3; step();
        chk("R9 fill beats drain", {7'd0, h_status[1]}, 8'h01);
        chk("R9 overrun beats clear", {7'd0, c_overrun}, 8'h01);
        c_wr = 1; c_wdata = 8'h44; h_rd = 1; step();
        chk("R9 post beats take", {7'd0, h_status[0]}, 8'h01);
        // R5 host reset clears ibf only
        h_rst = 1; h_wr = 1; step();
        chk("R5 host reset", h_status[1:0], 2'b01);

        // random phase against the model
        for (int i = 0; i < 400; i++) begin
            h_wr = ($urandom % 3) == 0; h_cmd_sel = $urandom; h_wdata = $urandom;
            h_rd = ($urandom % 3) == 0; c_rd = ($urandom % 3) == 0;
            c_wr = ($urandom % 4) == 0; c_wdata = $urandom;
            c_ctl_wr = ($urandom % 5) == 0; c_ctl_wdata = $urandom;
            c_stat_wr = ($urandom % 6) == 0; c_busy = $urandom; c_gflags = $urandom;
            h_rst = ($urandom % 29) == 0;
            step();
        end

        // R5 controller reset clears everything
        c_ctl_wr = 1; c_ctl_wdata = 8'h03; c_stat_wr = 1; c_busy = 1; c_gflags = 4'hF;
        h_wr = 1; step();
        @(negedge clk); rst_n = 0; #1;
        chk("R5 ctl reset status", h_status, 8'h00);
        chk("R5 ctl reset irqs", {6'd0, irq_ibf, irq_obe}, 8'h00);
        @(negedge clk); rst_n = 1;
        step();
        chk("R5 enables cleared", {7'd0, irq_obe}, 8'h00);
        finish_run();
    end
endmodule